// File: doc/BRIEF.md
# Prescaled Down-Counting Timer with Pin Output Modes

This block is a free-running interval timer. The clock is divided by four and then by a programmable 8-bit prescaler. The result decrements a 16-bit counter. When the counter has reached zero and takes its next step, the block reloads the counter from the most recently written value and emits an end-of-count pulse. That pulse drives one output pin in one of three ways:
- The pin is held high while its output function is off.
- The pin toggles at each end of count, which gives a square wave.
- The pin takes a level bit at each end of count, which allows pulse-width modulation.

A byte-wide register port holds four registers: counter high, counter low, prescaler and control. Writing a counter or prescaler register restarts the time base. The timer's end-of-count pulse shares one interrupt request line with an external interrupt input. A control bit chooses which of the two drives the line. The choice is a plain combinational select, so changing the select bit can itself make an edge on the line.

Top module: `prog_timer`

## Requirements
- R1: After reset the pin reads high and no end-of-count or timer interrupt pulse is present. Register reads return 0xFF, 0xFF, 0xFF and 0x00 at addresses 0, 1, 2 and 3.
- R2: While running, end-of-count pulses are single clock cycles spaced exactly 4 x (prescaler+1) x (count+1) clocks apart.
- R3: A write to address 0 (counter bits 15:8) or address 1 (counter bits 7:0) sets that byte of the reload value and restarts the count. The next end of count then falls 4 x (prescaler+1) x (reload+1) clocks after the write edge. Every end of count reloads the counter from the reload value. Reading address 0 or 1 returns the live counter bytes.
- R4: When control bit 0 (run) is 0, the counter, the prescaler and the divide-by-four stage hold, no end of count occurs, and the pin keeps its level.
- R5: With control bits 5 and 4 both 0, the pin output is high.
- R6: With control bit 5 = 0 and bit 4 = 1, the pin inverts at every end of count and at no other time.
- R7: With control bit 5 = 1, control bit 4 is copied to the pin only at each end of count. A change of bit 4 between end-of-count events does not reach the pin until the next one.
- R8: With control bit 2 = 0, the interrupt line carries the end-of-count pulse. With bit 2 = 1, the line follows the external interrupt input in the same cycle and timer pulses are kept off it.
- R9: Address 2 reads back the prescaler value. Address 3 reads back control bits 0, 2, 4 and 5, and its other bits read 0. A prescaler write also restarts the count.
- R10: With prescaler 0 and count 0 the pin produces a square wave of period 8 clocks (333 ns at 24 MHz). With prescaler 255 the end-of-count interval scales by 256, so the longest period is 2 x 4 x 256 x 65536 clocks (about 5.59 s at 24 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 counter high, 1 counter low, 2 prescaler, 3 control |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| ext_irq_i | input | 1 | External interrupt source |
| timer_out_o | output | 1 | Timer output pin |
| eoc_o | output | 1 | End-of-count pulse |
| irq_o | output | 1 | Shared interrupt request line |

## Verification
The bench runs the time base with several prescaler and count pairs:
- A short interval (prescaler 1, count 4).
- The minimum (0, 0).
- A large prescaler (255, 1).

Together these separate the divide-by-four stage, the prescaler and the counter contributions to the interval. A counter rewrite in mid-interval shows whether a restart takes effect from the write edge or only from the next natural expiry. The pin is checked in every mode:
- A level change made between events in the level-copy mode must stay off the pin until the next end of count.
- A stop period must freeze both the count and the pin.

The external interrupt is toggled with the select bit both set and clear, which tells the shared line's two sources apart.

// File: rtl/ptim_pkg.sv
package ptim_pkg;

    // Register addresses on the byte port
    localparam logic [1:0] ADDR_CNT_HI = 2'd0;
    localparam logic [1:0] ADDR_CNT_LO = 2'd1;
    localparam logic [1:0] ADDR_PSC    = 2'd2;
    localparam logic [1:0] ADDR_CTL    = 2'd3;

    // Control register bit positions
    localparam int CTL_RUN     = 0;
    localparam int CTL_IRQ_EXT = 2;
    localparam int CTL_LVL     = 4;
    localparam int CTL_PWM     = 5;

    // Pin behaviour, {pwm, lvl}
    typedef enum logic [1:0] {
        OUT_OFF    = 2'b00,
        OUT_TOGGLE = 2'b01,
        OUT_PWM_LO = 2'b10,
        OUT_PWM_HI = 2'b11
    } out_mode_e;

    typedef struct packed {
        logic pwm;
        logic lvl;
        logic irq_ext;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/ptim_tick.sv
module ptim_tick #(
    parameter int DIV_W = 2,
    parameter int PSC_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [PSC_W-1:0] psc_load_i,
    output logic             step_o
);
    localparam logic [DIV_W-1:0] DIV_LAST = '1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [PSC_W-1:0] psc;
    } tick_state_t;

    tick_state_t q, d;
    logic        step;

    always_comb begin
        d    = q;
        step = 1'b0;
        if (restart_i) begin
            d.div = '0;
            d.psc = psc_load_i;
        end else if (run_i) begin
            if (q.div == DIV_LAST) begin
                d.div = '0;
                if (q.psc == '0) begin
                    d.psc = psc_load_i;
                    step  = 1'b1;
                end else begin
                    d.psc = q.psc - 1'b1;
                end
            end else begin
                d.div = q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.div <= '0;
            q.psc <= '1;
        end else begin
            q <= d;
        end
    end

    assign step_o = step;

endmodule

// File: rtl/ptim_count.sv
module ptim_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o,
    output logic             eoc_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             eoc;
    } cnt_state_t;

    cnt_state_t q, d;
    logic       expire;

    always_comb begin
        d      = q;
        d.eoc  = 1'b0;
        expire = 1'b0;
        if (restart_i) begin
            d.cnt = reload_i;
        end else if (step_i) begin
            if (q.cnt == '0) begin
                d.cnt  = reload_i;
                d.eoc  = 1'b1;
                expire = 1'b1;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.cnt <= '1;
            q.eoc <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cnt_o    = q.cnt;
    assign expire_o = expire;
    assign eoc_o    = q.eoc;

endmodule

// File: rtl/ptim_pin.sv
module ptim_pin (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  ptim_pkg::out_mode_e  mode_i,
    input  logic                 expire_i,
    output logic                 pin_o
);
    import ptim_pkg::*;

    typedef struct packed {
        logic pin;
    } pin_state_t;

    pin_state_t q, d;

    always_comb begin
        d = q;
        case (mode_i)
            OUT_OFF:    d.pin = 1'b1;
            OUT_TOGGLE: if (expire_i) d.pin = ~q.pin;
            OUT_PWM_LO: if (expire_i) d.pin = 1'b0;
            OUT_PWM_HI: if (expire_i) d.pin = 1'b1;
            default:    d.pin = q.pin;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.pin <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign pin_o = (mode_i == OUT_OFF) ? 1'b1 : q.pin;

endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic              ext_irq_i,
    output logic              timer_out_o,
    output logic              eoc_o,
    output logic              irq_o
);
    import ptim_pkg::*;

    localparam int CNT_W = 2 * DATA_W;
    localparam int PSC_W = DATA_W;

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic [PSC_W-1:0] presc;
        ctrl_t            ctrl;
    } regs_t;

    regs_t q, d;
    logic  restart;

    always_comb begin
        d       = q;
        restart = 1'b0;
        if (reg_wr_i) begin
            case (reg_addr_i)
                ADDR_CNT_HI: begin
                    d.reload[CNT_W-1:DATA_W] = reg_wdata_i;
                    restart = 1'b1;
                end
                ADDR_CNT_LO: begin
                    d.reload[DATA_W-1:0] = reg_wdata_i;
                    restart = 1'b1;
                end
                ADDR_PSC: begin
                    d.presc = reg_wdata_i;
                    restart = 1'b1;
                end
                default: begin
                    d.ctrl.run     = reg_wdata_i[CTL_RUN];
                    d.ctrl.irq_ext = reg_wdata_i[CTL_IRQ_EXT];
                    d.ctrl.lvl     = reg_wdata_i[CTL_LVL];
                    d.ctrl.pwm     = reg_wdata_i[CTL_PWM];
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.reload <= '1;
            q.presc  <= '1;
            q.ctrl   <= '0;
        end else begin
            q <= d;
        end
    end

    logic             step;
    logic             expire;
    logic             eoc;
    logic [CNT_W-1:0] cnt;
    out_mode_e        mode;

    assign mode = out_mode_e'({q.ctrl.pwm, q.ctrl.lvl});

    ptim_tick #(.DIV_W(DIV_W), .PSC_W(PSC_W)) u_tick (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (q.ctrl.run),
        .restart_i  (restart),
        .psc_load_i (d.presc),
        .step_o     (step)
    );

    ptim_count #(.CNT_W(CNT_W)) u_count (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .step_i    (step),
        .restart_i (restart),
        .reload_i  (d.reload),
        .cnt_o     (cnt),
        .expire_o  (expire),
        .eoc_o     (eoc)
    );

    ptim_pin u_pin (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .mode_i   (mode),
        .expire_i (expire),
        .pin_o    (timer_out_o)
    );

    // Read path
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_CNT_HI: reg_rdata_o = cnt[CNT_W-1:DATA_W];
            ADDR_CNT_LO: reg_rdata_o = cnt[DATA_W-1:0];
            ADDR_PSC:    reg_rdata_o = q.presc;
            default: begin
                reg_rdata_o[CTL_RUN]     = q.ctrl.run;
                reg_rdata_o[CTL_IRQ_EXT] = q.ctrl.irq_ext;
                reg_rdata_o[CTL_LVL]     = q.ctrl.lvl;
                reg_rdata_o[CTL_PWM]     = q.ctrl.pwm;
            end
        endcase
    end

    assign eoc_o = eoc;
    // Plain select: flipping the source can itself create an edge
    assign irq_o = q.ctrl.irq_ext ? ext_irq_i : eoc;

    // Named taps for the bound checker
    logic [1:0]       mode_w;
    logic             run_w;
    logic             irq_ext_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] reload_w;
    assign mode_w    = {q.ctrl.pwm, q.ctrl.lvl};
    assign run_w     = q.ctrl.run;
    assign irq_ext_w = q.ctrl.irq_ext;
    assign cnt_w     = cnt;
    assign reload_w  = q.reload;

endmodule

// File: rtl/ptim_chk.sv
module ptim_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             eoc_i,
    input logic             out_i,
    input logic             irq_i,
    input logic [1:0]       mode_i,
    input logic             run_i,
    input logic             irq_ext_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic [CNT_W-1:0] reload_i
);
    assert_eoc_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eoc_i |=> !eoc_i);

    assert_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eoc_i |-> (cnt_i == reload_i));

    assert_stop_no_eoc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(run_i) |-> !eoc_i);

    assert_toggle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(mode_i) == 2'b01 && mode_i == 2'b01 && eoc_i) |-> (out_i != $past(out_i)));

    assert_pwm_copy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(mode_i[1]) && mode_i == $past(mode_i) && eoc_i) |-> (out_i == $past(mode_i[0])));

    assert_pin_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == $past(mode_i) && mode_i != 2'b00 && !eoc_i) |-> $stable(out_i));

    assert_irq_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!irq_ext_i && $stable(irq_ext_i) && irq_i) |-> $past(run_i));

endmodule

bind prog_timer ptim_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .eoc_i     (eoc_o),
    .out_i     (timer_out_o),
    .irq_i     (irq_o),
    .mode_i    (mode_w),
    .run_i     (run_w),
    .irq_ext_i (irq_ext_w),
    .cnt_i     (cnt_w),
    .reload_i  (reload_w)
);

// File: tb/prog_timer_tb.sv
module prog_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic       ext = 1'b0;
    logic [7:0] rdata;
    logic       tout, eoc, irq;

    prog_timer u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .ext_irq_i   (ext),
        .timer_out_o (tout),
        .eoc_o       (eoc),
        .irq_o       (irq)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int eoc_times[$];

    // Behavioural reference state
    int m_div = 0, m_psc = 255, m_cnt = 65535, m_rel = 65535;
    int m_presc = 255, m_ctrl = 0, m_pin = 1, m_eoc = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        int oc;
        int en;
        int md;
        cyc++;
        if (!rst_n) begin
            m_div = 0; m_psc = 255; m_cnt = 65535; m_rel = 65535;
            m_presc = 255; m_ctrl = 0; m_pin = 1; m_eoc = 0;
        end else begin
            oc = m_ctrl;
            en = 0;
            if (wr && addr != 2'd3) begin
                if (addr == 2'd0) m_rel = (m_rel & 255) | (int'(wdata) << 8);
                if (addr == 2'd1) m_rel = (m_rel & 'hFF00) | int'(wdata);
                if (addr == 2'd2) m_presc = int'(wdata);
                m_div = 0;
                m_psc = m_presc;
                m_cnt = m_rel;
            end else if ((oc & 1) != 0) begin
                if (m_div == 3) begin
                    m_div = 0;
                    if (m_psc == 0) begin
                        m_psc = m_presc;
                        if (m_cnt == 0) begin
                            m_cnt = m_rel;
                            en = 1;
                        end else m_cnt--;
                    end else m_psc--;
                end else m_div++;
            end
            md = (oc >> 4) & 3;
            if (md == 0) m_pin = 1;
            else if (md == 1) begin if (en != 0) m_pin = 1 - m_pin; end
            else if (en != 0) m_pin = (oc >> 4) & 1;
            if (wr && addr == 2'd3) m_ctrl = int'(wdata) & 'h35;
            m_eoc = en;
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        int md, e_out, e_irq, e_rd;
        string ptag, rtag;
        if (cyc > 100000) begin
            check(1'b0, "watchdog", cyc, 100000);
            finish_run();
        end
        if (rst_n) begin
            md    = (m_ctrl >> 4) & 3;
            e_out = (md == 0) ? 1 : m_pin;
            ptag  = (md == 0) ? "R5" : (md == 1) ? "R6" : "R7";
            e_irq = ((m_ctrl & 4) != 0) ? int'(ext) : m_eoc;
            case (addr)
                2'd0: begin e_rd = m_cnt >> 8;  rtag = "R3"; end
                2'd1: begin e_rd = m_cnt & 255; rtag = "R3"; end
                2'd2: begin e_rd = m_presc;     rtag = "R9"; end
                default: begin e_rd = m_ctrl;   rtag = "R9"; end
            endcase
            check(int'(tout) == e_out, {ptag, " pin"}, int'(tout), e_out);
            check(int'(eoc) == m_eoc, "R2 eoc", int'(eoc), m_eoc);
            check(int'(irq) == e_irq, "R8 irq", int'(irq), e_irq);
            check(int'(rdata) == e_rd, {rtag, " rdata"}, int'(rdata), e_rd);
            if (eoc) eoc_times.push_back(cyc);
        end
    end

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] v);
        @(posedge clk); #1;
        wr = 1'b1; addr = a; wdata = v;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic rd_reg(input logic [1:0] a, output int v);
        @(posedge clk); #1;
        addr = a;
        @(negedge clk);
        v = int'(rdata);
    endtask

    task automatic gaps(input string req, input int exp);
        if (eoc_times.size() < 2) check(1'b0, req, eoc_times.size(), 2);
        for (int i = 1; i < eoc_times.size(); i++)
            check(eoc_times[i] - eoc_times[i-1] == exp, req,
                  eoc_times[i] - eoc_times[i-1], exp);
    endtask

    task automatic wait_eoc();
        int n;
        n = eoc_times.size();
        while (eoc_times.size() == n) @(negedge clk);
    endtask

    initial begin
        int v, w, t;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        check(tout == 1'b1, "R1 pin", int'(tout), 1);
        check(eoc == 1'b0, "R1 eoc", int'(eoc), 0);
        rd_reg(2'd0, v); check(v == 255, "R1 addr0", v, 255);
        rd_reg(2'd1, v); check(v == 255, "R1 addr1", v, 255);
        rd_reg(2'd2, v); check(v == 255, "R1 addr2", v, 255);
        rd_reg(2'd3, v); check(v == 0,   "R1 addr3", v, 0);

        // R2 interval, toggle mode R6
        wr_reg(2'd2, 8'd1);
        wr_reg(2'd0, 8'd0);
        wr_reg(2'd1, 8'd4);
        wr_reg(2'd3, 8'h11);
        eoc_times.delete();
        idle(200);
        gaps("R2 interval", 40);

        // R8 shared line follows external input
        wr_reg(2'd3, 8'h15);
        for (int i = 0; i < 12; i++) begin
            @(posedge clk); #1; ext = (i % 3) != 0;
            @(negedge clk);
            check(irq == ext, "R8 ext select", int'(irq), int'(ext));
        end
        ext = 1'b1;
        wr_reg(2'd3, 8'h11);
        ext = 1'b0;
        idle(50);

        // R7 level copy only at end of count
        wr_reg(2'd3, 8'h21);
        wait_eoc();
        idle(2);
        wr_reg(2'd3, 8'h31);
        @(negedge clk);
        check(tout == 1'b0, "R7 held until eoc", int'(tout), 0);
        wait_eoc();
        @(negedge clk);
        check(tout == 1'b1, "R7 copied at eoc", int'(tout), 1);

        // R4 stop holds count and pin
        wr_reg(2'd3, 8'h30);
        rd_reg(2'd1, v);
        eoc_times.delete();
        idle(100);
        rd_reg(2'd1, w);
        check(w == v, "R4 count held", w, v);
        check(eoc_times.size() == 0, "R4 no eoc", eoc_times.size(), 0);
        check(tout == 1'b1, "R4 pin held", int'(tout), 1);

        // R5 output off
        wr_reg(2'd3, 8'h01);
        idle(60);
        check(tout == 1'b1, "R5 pin high", int'(tout), 1);

        // R3 restart from write edge
        wr_reg(2'd3, 8'h11);
        idle(17);
        eoc_times.delete();
        wr_reg(2'd1, 8'd4);
        t = cyc;
        idle(45);
        check(eoc_times.size() > 0 && eoc_times[0] - t == 40, "R3 restart",
              (eoc_times.size() > 0) ? eoc_times[0] - t : -1, 40);

        // R10 minimum period and large prescaler
        wr_reg(2'd2, 8'd0);
        wr_reg(2'd1, 8'd0);
        eoc_times.delete();
        idle(40);
        gaps("R10 minimum", 4);
        wr_reg(2'd2, 8'd255);
        wr_reg(2'd1, 8'd1);
        eoc_times.delete();
        idle(6200);
        gaps("R10 prescale 255", 2048);

        // R9 readback
        wr_reg(2'd3, 8'hFF);
        rd_reg(2'd3, v); check(v == 'h35, "R9 ctrl mask", v, 'h35);
        wr_reg(2'd3, 8'h00);
        wr_reg(2'd0, 8'hFF);
        wr_reg(2'd1, 8'hFF);
        wr_reg(2'd2, 8'h5A);
        rd_reg(2'd0, v); check(v == 255, "R9 cnt hi", v, 255);
        rd_reg(2'd1, v); check(v == 255, "R9 cnt lo", v, 255);
        rd_reg(2'd2, v); check(v == 'h5A, "R9 presc", v, 'h5A);

        finish_run();
    end

endmodule